// File: doc/BRIEF.md
# Smart Card Transmit-End Flag

This block produces the transmit-end status flag of a character-oriented smart card transmitter. The flag tells software or a DMA engine that the last character has been sent, that its guard time has passed, and that the next character may be loaded. Time is measured in half-etu steps. An external divider pulses `half_tick` twice per elementary time unit, so intervals of 1.0, 1.5 and 2.5 etu are all exact.

A `char_start` strobe marks the first bit of each character. The block then counts half-etu steps for a span chosen by the guard-time and block-transfer mode bits, and the mode is sampled at the strobe. At the end of that span the flag is set, provided no error signal arrived from the card during the span and the data register is empty. The flag is also forced high whenever the transmitter is disabled and no error signal is pending.

Software clears the flag with a two-step handshake: a read that observes 1, then a write of 0. A DMA acknowledge clears it in one step. When a set and a clear land in the same cycle, the set wins.

Top module: `scte_txend_flag`

## Requirements
- R1: While `rst` is high at a clock edge, `tx_end` becomes 1 at that edge.
- R2: At any edge where `tx_en`=0 and `err_sig`=0, `tx_end` becomes 1. With `tx_en`=0 and `err_sig`=1 the flag is not forced and may be cleared.
- R3: After a `char_start` strobe with `mode_block`=0, the flag is set on the edge that samples the Nth `half_tick`. N is 5 when `mode_guard`=0 and 3 when `mode_guard`=1. Before that edge the interval causes no set.
- R4: With `mode_block`=1, N is 2, whatever the value of `mode_guard`. The mode bits are sampled only in the cycle of `char_start`.
- R5: The timed set happens only if `dr_empty`=1 on the final `half_tick`. An `err_sig` high in any cycle of a running interval (with `char_start` low) cancels that interval. A cancelled or failed interval sets nothing on later ticks.
- R6: A `char_start` while an interval is running restarts the count from zero. A `half_tick` in the same cycle as `char_start` is not counted.
- R7: A `sw_rd` while `tx_end`=1 arms the clear. A later `sw_wr` with `sw_wdata`=0 then clears the flag. Every `sw_wr` disarms. A `sw_wr` with `sw_wdata`=1 never clears, and a `sw_wr` of 0 without arming never clears.
- R8: `dma_ack` high at an edge clears `tx_end`.
- R9: If a set event (R2 or a timed set) and a clear event (R7 or R8) occur at the same edge, `tx_end` becomes 1.
- R10: The armed state is captured from the flag value at the read only. A set that occurs between a read that saw 0 and the following write of 0 does not arm the clear, so that write leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| err_sig | input | 1 | Error signal received from the card |
| dr_empty | input | 1 | Transmit data register empty |
| char_start | input | 1 | One-cycle strobe at start of a character |
| half_tick | input | 1 | One-cycle pulse every half etu |
| mode_guard | input | 1 | Guard-time mode bit |
| mode_block | input | 1 | Block-transfer mode bit |
| sw_rd | input | 1 | Software read strobe of the flag |
| sw_wr | input | 1 | Software write strobe of the flag |
| sw_wdata | input | 1 | Value written with `sw_wr` |
| dma_ack | input | 1 | DMA service acknowledge (clears flag) |
| tx_end | output | 1 | Transmit-end flag |

## Verification
On every cycle, the assertions check the forced set, the reset value, and that the flag can fall only after a DMA acknowledge or a written 0. They also check that a timed set is never overridden by a clear, that a write of 1 never clears, and that the flag never rises while an error signal is present with the transmitter enabled.

The exact half-etu count for each mode, restart on a new strobe, cancellation by an error or a full data register, and the read-then-write arming order all depend on history over many cycles. Only the bench's scenarios and its per-cycle reference model show these.

// File: rtl/scte_pkg.sv
package scte_pkg;

    // Default half-etu counts for each interval length
    localparam int HALF_LONG_DEF  = 5;
    localparam int HALF_MID_DEF   = 3;
    localparam int HALF_SHORT_DEF = 2;

    typedef struct packed {
        logic guard;
        logic block;
    } mode_t;

    typedef enum logic [1:0] {
        GAP_LONG  = 2'd0,
        GAP_MID   = 2'd1,
        GAP_SHORT = 2'd2
    } gap_e;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic force_set;
        logic timed_set;
        logic sw_clear;
        logic dma_clear;
    } flag_evt_t;

    // Block transfer overrides guard mode
    function automatic gap_e gap_select(input mode_t m);
        gap_e g;
        if (m.block)      g = GAP_SHORT;
        else if (m.guard) g = GAP_MID;
        else              g = GAP_LONG;
        return g;
    endfunction

    function automatic logic any_set(input flag_evt_t e);
        return e.force_set | e.timed_set;
    endfunction

    function automatic logic any_clear(input flag_evt_t e);
        return e.sw_clear | e.dma_clear;
    endfunction

endpackage

// File: rtl/scte_etu_timer.sv
module scte_etu_timer
    import scte_pkg::*;
#(
    parameter int HALF_LONG  = HALF_LONG_DEF,
    parameter int HALF_MID   = HALF_MID_DEF,
    parameter int HALF_SHORT = HALF_SHORT_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  half_tick,
    input  logic  err_sig,
    input  logic  dr_empty,
    input  mode_t mode,
    output logic  expire_set
);
    localparam int CNT_W = $clog2(HALF_LONG + 1);

    tmr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] load_val;
    logic             last_step;

    always_comb begin
        unique case (gap_select(mode))
            GAP_SHORT: load_val = CNT_W'(HALF_SHORT);
            GAP_MID:   load_val = CNT_W'(HALF_MID);
            default:   load_val = CNT_W'(HALF_LONG);
        endcase
    end

    assign last_step = (cnt_q == CNT_W'(1));

    always_comb begin
        st_d       = st_q;
        cnt_d      = cnt_q;
        expire_set = 1'b0;
        if (start) begin
            st_d  = TMR_RUN;
            cnt_d = load_val;
        end else if (st_q == TMR_RUN) begin
            if (err_sig) begin
                st_d = TMR_IDLE;
            end else if (half_tick) begin
                if (last_step) begin
                    st_d       = TMR_IDLE;
                    expire_set = dr_empty;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TMR_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/scte_clear_arm.sv
module scte_clear_arm (
    input  logic clk,
    input  logic rst,
    input  logic rd,
    input  logic wr,
    input  logic wdata,
    input  logic flag_q,
    output logic sw_clear
);
    logic armed_q;

    // Arm only from the value seen by the read itself
    always_ff @(posedge clk) begin
        if (rst)     armed_q <= 1'b0;
        else if (wr) armed_q <= 1'b0;
        else if (rd) armed_q <= flag_q;
    end

    assign sw_clear = wr & ~wdata & armed_q;

endmodule

// File: rtl/scte_flag_reg.sv
module scte_flag_reg
    import scte_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_evt_t evt,
    output logic      flag_q
);
    always_ff @(posedge clk) begin
        if (rst)                 flag_q <= 1'b1;
        else if (any_set(evt))   flag_q <= 1'b1;
        else if (any_clear(evt)) flag_q <= 1'b0;
    end

endmodule

// File: rtl/scte_txend_flag.sv
module scte_txend_flag
    import scte_pkg::*;
#(
    parameter int HALF_LONG  = HALF_LONG_DEF,
    parameter int HALF_MID   = HALF_MID_DEF,
    parameter int HALF_SHORT = HALF_SHORT_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic err_sig,
    input  logic dr_empty,
    input  logic char_start,
    input  logic half_tick,
    input  logic mode_guard,
    input  logic mode_block,
    input  logic sw_rd,
    input  logic sw_wr,
    input  logic sw_wdata,
    input  logic dma_ack,
    output logic tx_end
);
    mode_t     mode;
    flag_evt_t evt;
    logic      timed_set;
    logic      sw_clear;

    assign mode.guard = mode_guard;
    assign mode.block = mode_block;

    scte_etu_timer #(
        .HALF_LONG (HALF_LONG),
        .HALF_MID  (HALF_MID),
        .HALF_SHORT(HALF_SHORT)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (char_start),
        .half_tick (half_tick),
        .err_sig   (err_sig),
        .dr_empty  (dr_empty),
        .mode      (mode),
        .expire_set(timed_set)
    );

    scte_clear_arm u_arm (
        .clk     (clk),
        .rst     (rst),
        .rd      (sw_rd),
        .wr      (sw_wr),
        .wdata   (sw_wdata),
        .flag_q  (tx_end),
        .sw_clear(sw_clear)
    );

    assign evt.force_set = ~tx_en & ~err_sig;
    assign evt.timed_set = timed_set;
    assign evt.sw_clear  = sw_clear;
    assign evt.dma_clear = dma_ack;

    scte_flag_reg u_flag (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .flag_q(tx_end)
    );

endmodule

// File: rtl/scte_txend_chk.sv
module scte_txend_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic err_sig,
    input logic sw_wr,
    input logic sw_wdata,
    input logic dma_ack,
    input logic timed_set,
    input logic tx_end
);
    AST_RESET_SETS: assert property (@(posedge clk) rst |=> tx_end); // R1

    AST_FORCE_SET: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !err_sig) |=> tx_end); // R2

    AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_end) |-> $past(dma_ack || (sw_wr && !sw_wdata))); // R8

    AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (tx_end && sw_wr && sw_wdata && !dma_ack) |=> tx_end); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        timed_set |=> tx_end); // R9

    AST_ERR_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (err_sig && tx_en) |=> !$rose(tx_end)); // R5

endmodule

bind scte_txend_flag scte_txend_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .err_sig  (err_sig),
    .sw_wr    (sw_wr),
    .sw_wdata (sw_wdata),
    .dma_ack  (dma_ack),
    .timed_set(timed_set),
    .tx_end   (tx_end)
);

// File: tb/sim_scte_txend_flag.sv
module sim_scte_txend_flag;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 1'b0, err_sig = 1'b0, dr_empty = 1'b1;
    logic char_start = 1'b0, half_tick = 1'b0;
    logic mode_guard = 1'b0, mode_block = 1'b0;
    logic sw_rd = 1'b0, sw_wr = 1'b0, sw_wdata = 1'b0, dma_ack = 1'b0;
    logic tx_end;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // Reference model state
    bit m_flag = 1'b1;
    bit m_armed = 1'b0;
    bit m_busy = 1'b0;
    int m_left = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scte_txend_flag u0 (
        .clk(clk), .rst(rst), .tx_en(tx_en), .err_sig(err_sig),
        .dr_empty(dr_empty), .char_start(char_start), .half_tick(half_tick),
        .mode_guard(mode_guard), .mode_block(mode_block), .sw_rd(sw_rd),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .dma_ack(dma_ack), .tx_end(tx_end)
    );

    function automatic int span_for(bit g, bit b);
        if (b) return 2;
        return g ? 3 : 5;
    endfunction

    // Behavioural model of the flag, advanced on each rising edge
    always @(posedge clk) begin
        bit setv, clrv, timed;
        timed = 1'b0;
        if (rst) begin
            m_flag = 1'b1; m_armed = 1'b0; m_busy = 1'b0; m_left = 0;
        end else begin
            if (char_start) begin
                m_busy = 1'b1;
                m_left = span_for(mode_guard, mode_block);
            end else if (m_busy && err_sig) begin
                m_busy = 1'b0;
            end else if (m_busy && half_tick) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 1'b0;
                    timed = dr_empty;
                end
            end
            setv = (!tx_en && !err_sig) || timed;
            clrv = dma_ack || (sw_wr && !sw_wdata && m_armed);
            if (sw_wr) m_armed = 1'b0;
            else if (sw_rd) m_armed = m_flag;
            if (setv) m_flag = 1'b1;
            else if (clrv) m_flag = 1'b0;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        total++;
        if (tx_end !== m_flag) begin
            bad++;
            $display("FAIL model R3/R7/R9 cycle %0d: actual=%0b expected=%0b", cycles, tx_end, m_flag);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit exp, input string tag);
        total++;
        if (tx_end !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, tx_end, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        half_tick = 1'b1; @(negedge clk);
        half_tick = 1'b0; @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic start_char();
        char_start = 1'b1; @(negedge clk);
        char_start = 1'b0;
    endtask

    task automatic sw_read();
        sw_rd = 1'b1; @(negedge clk);
        sw_rd = 1'b0;
    endtask

    task automatic sw_write(input bit d);
        sw_wr = 1'b1; sw_wdata = d; @(negedge clk);
        sw_wr = 1'b0; sw_wdata = 1'b0;
    endtask

    task automatic dma_clear();
        dma_ack = 1'b1; @(negedge clk);
        dma_ack = 1'b0;
    endtask

    task automatic set_mode(input bit g, input bit b);
        mode_guard = g; mode_block = b;
    endtask

    initial begin
        @(negedge clk);
        idle(3);
        chk(1'b1, "R1 reset value");
        tx_en = 1'b1;
        idle(1);
        rst = 1'b0;
        idle(2);

        // R7: write 0 without read keeps flag
        sw_write(1'b0);
        chk(1'b1, "R7 unarmed write 0");
        // R7: read then write 1 keeps flag
        sw_read(); sw_write(1'b1);
        chk(1'b1, "R7 write 1 no effect");
        // R7: read then write 0 clears
        sw_read(); sw_write(1'b0);
        chk(1'b0, "R7 read-then-write clears");

        // R3: long interval, 5 half steps
        set_mode(1'b0, 1'b0);
        start_char(); ticks(4);
        chk(1'b0, "R3 long interval before end");
        tick();
        chk(1'b1, "R3 long interval end");

        // R8
        dma_clear();
        chk(1'b0, "R8 dma clear");

        // R3: mid interval, 3 half steps
        set_mode(1'b1, 1'b0);
        start_char(); ticks(2);
        chk(1'b0, "R3 mid interval before end");
        tick();
        chk(1'b1, "R3 mid interval end");

        // R4: block mode, guard 0 and 1
        dma_clear(); set_mode(1'b0, 1'b1);
        start_char(); tick();
        chk(1'b0, "R4 short gm0 before end");
        set_mode(1'b0, 1'b0); // mode change after start is ignored
        tick();
        chk(1'b1, "R4 short gm0 end");
        dma_clear(); set_mode(1'b1, 1'b1);
        start_char(); ticks(2);
        chk(1'b1, "R4 short gm1 end");

        // R6: restart mid-interval
        dma_clear(); set_mode(1'b0, 1'b0);
        start_char(); ticks(3);
        start_char(); ticks(4);
        chk(1'b0, "R6 restart not yet expired");
        tick();
        chk(1'b1, "R6 restart expired");

        // R6: tick coincident with start is not counted
        dma_clear(); set_mode(1'b0, 1'b1);
        char_start = 1'b1; half_tick = 1'b1; @(negedge clk);
        char_start = 1'b0; half_tick = 1'b0; @(negedge clk);
        tick();
        chk(1'b0, "R6 start-cycle tick ignored");
        tick();
        chk(1'b1, "R6 interval after start-cycle tick");

        // R5: error cancels interval
        dma_clear();
        start_char();
        err_sig = 1'b1; @(negedge clk); err_sig = 1'b0;
        ticks(3);
        chk(1'b0, "R5 error cancels");

        // R5: data register full at final tick
        start_char(); tick();
        dr_empty = 1'b0; tick();
        chk(1'b0, "R5 register full at end");
        dr_empty = 1'b1; ticks(2);
        chk(1'b0, "R5 no late set");

        // R9: timed set and dma clear in same cycle
        start_char(); tick();
        half_tick = 1'b1; dma_ack = 1'b1; @(negedge clk);
        half_tick = 1'b0; dma_ack = 1'b0; @(negedge clk);
        chk(1'b1, "R9 timed set beats dma");

        // R10: read saw 0, then set, then write 0 -> stays 1
        dma_clear();
        sw_read();
        start_char(); ticks(2);
        chk(1'b1, "R10 set after read");
        sw_write(1'b0);
        chk(1'b1, "R10 write 0 not armed");
        // R10: read saw 1, set in between, write 0 clears
        sw_read(); start_char(); ticks(2);
        sw_write(1'b0);
        chk(1'b0, "R10 armed by earlier read");

        // R2 + R9: force with dma in same cycle
        tx_en = 1'b0; dma_ack = 1'b1; @(negedge clk);
        dma_ack = 1'b0;
        chk(1'b1, "R2 force beats dma");
        // R2: error pending, no force
        err_sig = 1'b1; @(negedge clk);
        dma_clear();
        chk(1'b0, "R2 no force while error");
        err_sig = 1'b0; @(negedge clk);
        chk(1'b1, "R2 force after error drops");
        tx_en = 1'b1;
        idle(2);

        // Mixed traffic checked by the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom;
            tx_en      = (r[3:0] != 4'd0);
            err_sig    = (r[7:4] == 4'd0);
            dr_empty   = (r[10:8] != 3'd0);
            char_start = (r[15:11] == 5'd0);
            half_tick  = r[16] & r[17];
            mode_guard = r[18];
            mode_block = r[19] & r[20];
            sw_rd      = (r[23:21] == 3'd0);
            sw_wr      = (r[26:24] == 3'd0);
            sw_wdata   = r[27] & r[28];
            dma_ack    = (r[31:29] == 3'd0);
            @(negedge clk);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule